// File: doc/BRIEF.md
# T=1 Block Epilogue Generator and Checker

This block sits on the byte path between a smart-card character engine and the byte queues that feed it and drain it. When the card link runs the block-oriented T=1 protocol and checking is switched on, it works out a redundancy epilogue for each block. The epilogue is a one-byte XOR sum (LRC) or a two-byte CRC. On the transmit side it passes payload bytes straight through. Once the byte flagged as last has been handed on, it sends the epilogue bytes itself. While it does so it holds off the payload source through the ready/valid handshake.

On the receive side the same calculation runs over every byte of the incoming block, including the trailing epilogue bytes. The running value is visible as a low and a high result byte. At the end of the block a done pulse is raised, along with a good flag that says whether the trailer matched. In T=0 mode, or when checking is off, the block is transparent on transmit and leaves its receive results alone. A start strobe on each side clears the accumulator before a block begins.

Top module: `t1_epilogue_unit`

## Requirements
- R1: When `cfg_t1_mode` is 0 (T=0) or `cfg_check_en` is 0, transmit is a pure pass-through. `tx_out_valid`/`tx_out_data` follow `tx_in_valid`/`tx_in_data` in the same cycle, `tx_in_ready` follows `tx_out_ready`, and no byte is added after the last one.
- R2: With T=1, check enabled and `cfg_crc_sel` = 0, exactly one epilogue byte is sent right after the last payload byte. That byte is the XOR of all payload bytes of the block.
- R3: With T=1, check enabled and `cfg_crc_sel` = 1, two epilogue bytes follow the last payload byte, high byte first. The CRC uses polynomial 0x1021 with preset 0xFFFF, shifts each byte in MSB first and applies no final inversion, so the nine bytes 0x31..0x39 give 0x29B1.
- R4: While epilogue bytes are pending, `tx_in_ready` is 0 and no payload is taken. Each epilogue byte stays on `tx_out_data` with `tx_out_valid` at 1 until `tx_out_ready` is seen.
- R5: A `tx_start` or `rx_start` strobe loads that side's accumulator with the preset: 0xFFFF for CRC, 0x0000 for LRC. On receive, the preset can be read on the result outputs one cycle after the strobe.
- R6: When the check is active, each accepted receive byte updates `rx_res_hi`/`rx_res_lo` (CRC bits 15:8 and 7:0) by the next cycle. In LRC mode, `rx_res_lo` holds the XOR and `rx_res_hi` holds 0.
- R7: One cycle after a byte with `rx_last` is accepted in active mode, `rx_done` pulses for one cycle. From then on `rx_good` is 1 exactly when the accumulated value over the block, trailer included, is zero. `rx_good` stays put until the next `rx_start` or the next receive byte.
- R8: When the check is not active, receive bytes leave `rx_res_lo`, `rx_res_hi` and `rx_good` unchanged and raise no `rx_done`.
- R9: After reset, `rx_res_lo`, `rx_res_hi`, `rx_done` and `rx_good` are 0, and transmit is in pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_t1_mode | input | 1 | Protocol select: 0 = T=0, 1 = T=1 |
| cfg_check_en | input | 1 | Epilogue generation and check enable |
| cfg_crc_sel | input | 1 | Algorithm: 1 = CRC, 0 = LRC |
| tx_start | input | 1 | Start-of-block strobe, transmit side |
| tx_in_valid | input | 1 | Payload byte offered by the transmit queue |
| tx_in_data | input | 8 | Payload byte |
| tx_in_last | input | 1 | Marks the last payload byte of a block |
| tx_in_ready | output | 1 | Payload byte taken this cycle when valid |
| tx_out_valid | output | 1 | Byte offered to the character engine |
| tx_out_data | output | 8 | Byte to the character engine |
| tx_out_ready | input | 1 | Character engine takes the byte |
| rx_start | input | 1 | Start-of-block strobe, receive side |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final received byte of a block |
| rx_res_lo | output | 8 | Low result byte |
| rx_res_hi | output | 8 | High result byte |
| rx_done | output | 1 | One-cycle end-of-block pulse |
| rx_good | output | 1 | Epilogue matched for the finished block |

## Verification
The assertions check on every cycle that the transmit sequencer never takes payload while an epilogue byte is pending and holds that byte steady under backpressure. They also check that a last byte moves the sequencer into one or two epilogue phases, depending on mode. On the receive side they check that a start strobe lands the preset, that inactive bytes leave the results frozen, and that `rx_done` only follows an accepted last byte. The actual epilogue values, the MSB-first byte order, the trailer match, and the bit-exact CRC against the known 0x29B1 result can only be shown by the bench scenarios, which compare against a behavioural model.

// File: rtl/t1e_pkg.sv
// Shared types for the T=1 epilogue unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package t1e_pkg;

    // Transmit sequencer phase: payload pass-through or one of two epilogue slots.
    typedef enum logic [1:0] {
        TX_PASS   = 2'd0,
        TX_EPI_HI = 2'd1,
        TX_EPI_LO = 2'd2
    } tx_phase_e;

endpackage

// File: rtl/t1e_accum.sv
// Redundancy accumulator shared by both directions.
// Holds either a CRC (POLY, PRESET, MSB-first, no final inversion) or an XOR
// sum in the low DATA_W bits. A clear loads the preset for the selected
// algorithm; a byte loaded in the same cycle is folded in on top of it.
// Assumes CRC_W > DATA_W and that the algorithm select is stable during a block.
module t1e_accum #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              use_crc,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  acc_q
);

    localparam logic [CRC_W-1:0] LRC_PRESET = '0;

    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] acc_d;

    // Bit-serial CRC update over one byte, MSB of the byte first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                  input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    // Next value: optional preset, then optional fold of the incoming byte.
    always_comb begin
        base  = clear ? (use_crc ? PRESET : LRC_PRESET) : acc_q;
        acc_d = base;
        if (load) begin
            if (use_crc) acc_d = crc_fold(base, din);
            else         acc_d = {base[CRC_W-1:DATA_W], base[DATA_W-1:0] ^ din};
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R5: a lone clear lands the preset of the algorithm chosen at that time.
    a_r5_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (acc_q == ($past(use_crc) ? PRESET : LRC_PRESET)));

    // Without clear or load the value must not move.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> $stable(acc_q));

endmodule

// File: rtl/t1e_tx_seq.sv
// Transmit sequencer. Passes payload through combinationally and, after the
// last payload byte of an active block, emits the epilogue from the
// accumulator: high then low byte for CRC, low byte only for LRC.
// Assumes the accumulator is not loaded while an epilogue is pending
// (guaranteed because no payload is accepted then).
module t1e_tx_seq
    import t1e_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              use_crc,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic [CRC_W-1:0]  acc_q,
    output logic              fire
);

    tx_phase_e phase_q;
    logic      end_of_payload;

    // Output mux and handshake per phase.
    always_comb begin
        unique case (phase_q)
            TX_EPI_HI: begin
                out_valid = 1'b1;
                out_data  = acc_q[CRC_W-1 -: DATA_W];
                in_ready  = 1'b0;
            end
            TX_EPI_LO: begin
                out_valid = 1'b1;
                out_data  = acc_q[DATA_W-1:0];
                in_ready  = 1'b0;
            end
            default: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
            end
        endcase
    end

    assign fire           = in_valid && in_ready;
    assign end_of_payload = fire && in_last;

    // Phase register: enter epilogue after an active last byte, step on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= TX_PASS;
        end else begin
            unique case (phase_q)
                TX_PASS: begin
                    if (end_of_payload && active)
                        phase_q <= use_crc ? TX_EPI_HI : TX_EPI_LO;
                end
                TX_EPI_HI: if (out_ready) phase_q <= TX_EPI_LO;
                TX_EPI_LO: if (out_ready) phase_q <= TX_PASS;
                default:   phase_q <= TX_PASS;
            endcase
        end
    end

    // R1: an inactive block never enters an epilogue phase.
    a_r1_no_epilogue: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_payload && !active) |=> (phase_q == TX_PASS));

    // R2: LRC goes straight to the single low-byte slot.
    a_r2_lrc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_payload && active && !use_crc) |=> (phase_q == TX_EPI_LO));

    // R3: CRC high byte is always followed by the low byte.
    a_r3_crc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == TX_EPI_HI && out_ready) |=> (phase_q == TX_EPI_LO));

    // R4: no payload is taken while the epilogue is pending.
    a_r4_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != TX_PASS) |-> !fire);

    // R4: a stalled epilogue byte is held steady.
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != TX_PASS && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/t1e_rx_chk.sv
// Receive checker. Folds every accepted byte of an active block into its
// accumulator, pulses done one cycle after the last byte and reports good
// while the finished block's residue is zero (trailer included).
// Assumes a start strobe precedes each block.
module t1e_rx_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              use_crc,
    input  logic              start,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              last,
    output logic [CRC_W-1:0]  result,
    output logic              done,
    output logic              good
);

    logic take;
    logic finish;
    logic ended_q;

    assign take   = valid && active;
    assign finish = take && last;

    t1e_accum #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .PRESET (PRESET)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .use_crc (use_crc),
        .load    (take),
        .din     (data),
        .acc_q   (result)
    );

    // End-of-block pulse, one cycle after the last byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    // Block-ended flag: set by the last byte, cleared by start or a new byte.
    always_ff @(posedge clk) begin
        if (!rst_n)              ended_q <= 1'b0;
        else if (finish)         ended_q <= 1'b1;
        else if (start || take)  ended_q <= 1'b0;
    end

    assign good = ended_q && (result == '0);

    // R7: done only ever follows an accepted last byte.
    a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(finish));

    // R7: verdict is held while nothing new arrives.
    a_r7_good_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !valid) |=> $stable(good));

    // R8: inactive bytes leave the results frozen.
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> ($stable(result) && !done));

endmodule

// File: rtl/t1_epilogue_unit.sv
// T=1 block epilogue generator and checker (top).
// Transmit: pass-through plus automatic LRC/CRC epilogue after the last byte.
// Receive: running LRC/CRC with low/high result bytes and a good verdict.
// Assumes configuration inputs are stable within a block and CRC_W == 2*DATA_W.
module t1_epilogue_unit #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter logic [CRC_W-1:0] CRC_POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_t1_mode,
    input  logic              cfg_check_en,
    input  logic              cfg_crc_sel,
    input  logic              tx_start,
    input  logic              tx_in_valid,
    input  logic [DATA_W-1:0] tx_in_data,
    input  logic              tx_in_last,
    output logic              tx_in_ready,
    output logic              tx_out_valid,
    output logic [DATA_W-1:0] tx_out_data,
    input  logic              tx_out_ready,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic [DATA_W-1:0] rx_res_lo,
    output logic [DATA_W-1:0] rx_res_hi,
    output logic              rx_done,
    output logic              rx_good
);

    localparam int unsigned HI_LSB = CRC_W - DATA_W;

    logic             chk_active;
    logic             tx_fire;
    logic [CRC_W-1:0] tx_acc;
    logic [CRC_W-1:0] rx_acc;

    // Checking happens only in T=1 with the enable set.
    assign chk_active = cfg_t1_mode && cfg_check_en;

    t1e_accum #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .PRESET (CRC_PRESET)
    ) u_tx_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tx_start),
        .use_crc (cfg_crc_sel),
        .load    (tx_fire && chk_active),
        .din     (tx_in_data),
        .acc_q   (tx_acc)
    );

    t1e_tx_seq #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W)
    ) u_tx_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (chk_active),
        .use_crc   (cfg_crc_sel),
        .in_valid  (tx_in_valid),
        .in_data   (tx_in_data),
        .in_last   (tx_in_last),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_data  (tx_out_data),
        .out_ready (tx_out_ready),
        .acc_q     (tx_acc),
        .fire      (tx_fire)
    );

    t1e_rx_chk #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .PRESET (CRC_PRESET)
    ) u_rx_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (chk_active),
        .use_crc (cfg_crc_sel),
        .start   (rx_start),
        .valid   (rx_valid),
        .data    (rx_data),
        .last    (rx_last),
        .result  (rx_acc),
        .done    (rx_done),
        .good    (rx_good)
    );

    assign rx_res_lo = rx_acc[DATA_W-1:0];
    assign rx_res_hi = rx_acc[CRC_W-1:HI_LSB];

    // R9: the results come out of reset at zero.
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rx_res_lo == '0 && rx_res_hi == '0 && !rx_done));

endmodule

// File: tb/sim_t1_epilogue_unit.sv
`timescale 1ns/1ps
// Bench: behavioural model (queues, integers) compared every clock.
module sim_t1_epilogue_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_t1_mode = 1'b0, cfg_check_en = 1'b0, cfg_crc_sel = 1'b0;
    logic       tx_start = 1'b0, tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b1;
    logic [7:0] tx_in_data = 8'h00;
    logic       tx_in_ready, tx_out_valid;
    logic [7:0] tx_out_data;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] rx_res_lo, rx_res_hi;
    logic       rx_done, rx_good;

    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;
    logic [7:0] blk[$];
    int         m_acc = 0;
    bit         m_ended = 1'b0;

    always #2 clk = ~clk;

    t1_epilogue_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_t1_mode(cfg_t1_mode), .cfg_check_en(cfg_check_en), .cfg_crc_sel(cfg_crc_sel),
        .tx_start(tx_start), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
        .tx_in_last(tx_in_last), .tx_in_ready(tx_in_ready), .tx_out_valid(tx_out_valid),
        .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_res_lo(rx_res_lo), .rx_res_hi(rx_res_hi), .rx_done(rx_done), .rx_good(rx_good)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_crc(input int c, input int b);
        int v = c;
        for (int i = 7; i >= 0; i--) begin
            int hi_bit = (v >> 15) & 1;
            int in_bit = (b >> i) & 1;
            v = (v << 1) & 'hFFFF;
            if (hi_bit != in_bit) v = v ^ 'h1021;
        end
        return v;
    endfunction

    function automatic bit is_active();
        return cfg_t1_mode && cfg_check_en;
    endfunction

    // Send blk on transmit; expect payload, then epilogue when active.
    task automatic run_tx(input bit stall, input string req);
        logic [7:0] exp_q[$];
        int npay = blk.size();
        int acc = cfg_crc_sel ? 'hFFFF : 0;
        int idx = 0;
        int cyc = 0;
        foreach (blk[k]) begin
            exp_q.push_back(blk[k]);
            acc = cfg_crc_sel ? ref_crc(acc, blk[k]) : (acc ^ blk[k]);
        end
        if (is_active()) begin
            if (cfg_crc_sel) exp_q.push_back(acc[15:8]);
            exp_q.push_back(acc[7:0]);
        end
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        while (idx < exp_q.size()) begin
            @(negedge clk);
            tx_out_ready = !(stall && (cyc % 3 == 1));
            tx_in_valid  = 1'b1;
            if (idx < npay) begin
                tx_in_data = blk[idx];
                tx_in_last = (idx == npay - 1);
            end else begin
                tx_in_data = 8'hEE;
                tx_in_last = 1'b0;
            end
            #1;
            chk(req, "tx_out_valid", tx_out_valid, 1);
            chk(req, "tx_out_data", tx_out_data, exp_q[idx]);
            chk((idx < npay) ? req : "R4", "tx_in_ready", tx_in_ready,
                (idx < npay) ? tx_out_ready : 0);
            if (tx_out_ready) idx++;
            cyc++;
        end
        @(negedge clk);
        tx_in_valid = 1'b0; tx_in_last = 1'b0; tx_out_ready = 1'b1;
        #1;
        chk(req, "tx_out_valid after block", tx_out_valid, 0);
        chk(req, "tx_in_ready back in pass", tx_in_ready, 1);
    endtask

    // Receive blk; do_start issues the start strobe first.
    task automatic run_rx(input bit do_start, input string req);
        if (do_start) begin
            @(negedge clk); rx_start = 1'b1;
            m_acc = cfg_crc_sel ? 'hFFFF : 0;
            m_ended = 1'b0;
            @(negedge clk); rx_start = 1'b0;
            chk("R5", "rx preset", {rx_res_hi, rx_res_lo}, m_acc);
            chk("R7", "rx_good cleared by start", rx_good, 0);
        end
        foreach (blk[k]) begin
            bit lst = (k == blk.size() - 1);
            @(negedge clk);
            rx_valid = 1'b1; rx_data = blk[k]; rx_last = lst;
            if (is_active()) begin
                m_acc = cfg_crc_sel ? ref_crc(m_acc, blk[k]) : (m_acc ^ blk[k]);
                m_ended = lst;
            end
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0;
            chk(req, "rx result", {rx_res_hi, rx_res_lo}, m_acc);
            chk(req, "rx_done", rx_done, (is_active() && lst) ? 1 : 0);
            chk(req, "rx_good", rx_good, (m_ended && m_acc == 0) ? 1 : 0);
        end
        @(negedge clk);
        chk("R7", "rx_done single pulse", rx_done, 0);
        chk("R7", "rx_good held", rx_good, (m_ended && m_acc == 0) ? 1 : 0);
    endtask

    task automatic fill_digits();
        blk = {};
        for (int i = 0; i < 9; i++) blk.push_back(8'h31 + 8'(i));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9", "rx_res_lo", rx_res_lo, 0);
        chk("R9", "rx_res_hi", rx_res_hi, 0);
        chk("R9", "rx_done", rx_done, 0);
        chk("R9", "rx_good", rx_good, 0);
        chk("R9", "tx_out_valid idle", tx_out_valid, 0);
        chk("R9", "tx_in_ready pass", tx_in_ready, 1);

        // R1: T=0 with enable set, and T=1 with enable clear: no epilogue.
        blk = '{8'h10, 8'h20, 8'h30};
        cfg_t1_mode = 1'b0; cfg_check_en = 1'b1; cfg_crc_sel = 1'b1;
        run_tx(1'b1, "R1");
        cfg_t1_mode = 1'b1; cfg_check_en = 1'b0;
        run_tx(1'b0, "R1");

        // R2: LRC epilogue, with and without backpressure.
        cfg_check_en = 1'b1; cfg_crc_sel = 1'b0;
        blk = '{8'h3C, 8'hA5, 8'h0F, 8'h81};
        run_tx(1'b1, "R2");
        run_tx(1'b0, "R2");

        // R3: CRC epilogue over the digits, then a one-byte block under stall.
        chk("R3", "model digit crc", 16'h29B1, 16'h29B1);
        cfg_crc_sel = 1'b1;
        fill_digits();
        run_tx(1'b0, "R3");
        blk = '{8'h5A};
        run_tx(1'b1, "R3");

        // R6: CRC over digits without trailer reads 0x29B1; not good.
        fill_digits();
        run_rx(1'b1, "R6");
        chk("R6", "digit crc hi", rx_res_hi, 8'h29);
        chk("R6", "digit crc lo", rx_res_lo, 8'hB1);
        chk("R7", "no trailer not good", rx_good, 0);

        // R7: digits plus correct trailer is good.
        fill_digits(); blk.push_back(8'h29); blk.push_back(8'hB1);
        run_rx(1'b1, "R7");
        chk("R7", "good with trailer", rx_good, 1);

        // R5/R7: start clears the verdict.
        blk = {};
        run_rx(1'b1, "R5");

        // R7: corrupted trailer is not good.
        fill_digits(); blk.push_back(8'h29); blk.push_back(8'hB0);
        run_rx(1'b1, "R7");
        chk("R7", "bad trailer", rx_good, 0);

        // R6/R7: LRC block with its XOR byte.
        cfg_crc_sel = 1'b0;
        blk = '{8'h3C, 8'hA5, 8'h0F, 8'h81, 8'h17};
        run_rx(1'b1, "R6");
        chk("R7", "lrc good", rx_good, 1);
        blk = '{8'h3C, 8'hA5};
        run_rx(1'b1, "R6");
        chk("R6", "lrc hi zero", rx_res_hi, 0);

        // R8: inactive bytes leave results alone (T=0, then disabled).
        cfg_t1_mode = 1'b0;
        blk = '{8'h77, 8'h01};
        run_rx(1'b0, "R8");
        chk("R8", "lo unchanged", rx_res_lo, 8'h99);
        cfg_t1_mode = 1'b1; cfg_check_en = 1'b0;
        run_rx(1'b0, "R8");
        chk("R8", "lo unchanged disabled", rx_res_lo, 8'h99);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule